// File: doc/BRIEF.md
# Deep Sleep Wake-Up Sequencer

This block holds the device clock off while the chip sits in a low-power state, and turns it back on only after a programmable settling delay. Software prepares it in two steps. It first writes a 16-bit settling count. It then sets an arm bit. From that point an external controller decides when sleep starts and ends, using an active-low request pin. A low level on the pin stops the clock. A high level starts a countdown on the always-on reference clock, so the oscillator has time to settle. When the countdown ends, the clock is released and a completion flag is raised. The flag stays set until software writes the arm bit again.

The pin comes from outside the reference-clock domain, so it passes through a two-flop synchroniser before any logic uses it. A small controller steps through five states: idle, armed, asleep, waking and done. A loadable down-counter times the settling delay. The clock-gate enable comes straight from a flip-flop, so it can change only on a reference-clock edge. The block carries no data stream. All of its pins are plain control and status signals, and it has no handshake.

Top module: `dslp_wake_seq`

## Requirements
- R1: After reset, `clk_gate_en` is 1, `done_flag` is 0, `arm_q` is 0, `cnt_q` is 0, and the internal synchroniser holds a "not sleeping" (high) level.
- R2: While the block is not armed, a low level on `sleep_req_n` has no effect. The clock stays enabled and the flag stays 0.
- R3: While armed, a low level on `sleep_req_n` drops `clk_gate_en` to 0 on the third reference edge after the pin falls: two edges pass through the synchroniser and one through the state register.
- R4: With count value N, a high level on `sleep_req_n` during sleep raises `clk_gate_en` on reference edge N+4 after the pin rises. The clock stays gated throughout the countdown.
- R5: The clock is released and `done_flag` rises on the same reference edge.
- R6: A write of 1 to the arm bit (`arm_wr`=1, `arm_wdata`=1) while done clears `done_flag` on the next edge and re-arms the block.
- R7: A write of 0 to the arm bit returns the block to idle on the next edge from any state. It also clears `done_flag` and sets `clk_gate_en` to 1 at once, even during sleep or wake-up.
- R8: The count field is 16 bits wide and is read back on `cnt_q`. The counter takes its value when wake-up begins. A count write during wake-up does not change the countdown in progress. The value 16'hFFFF is supported.
- R9: If the synchronised pin goes low during wake-up, the block returns to sleep. The next rise restarts the full programmed count.
- R10: `clk_gate_en` is driven by a register. It is 0 only while asleep or waking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_n | input | 1 | Asynchronous sleep request pin, low = sleep |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Arm bit value to write |
| cnt_wr | input | 1 | Write strobe for the settling count |
| cnt_wdata | input | 16 | Settling count value to write |
| arm_q | output | 1 | Arm bit readback |
| done_flag | output | 1 | Completion flag, set when the clock is released |
| cnt_q | output | 16 | Settling count readback |
| clk_gate_en | output | 1 | Clock enable for the device, 1 = running |

## Verification
The bench runs a clean sleep and wake with count 5, count 0 and count 16'hFFFF, and measures the edges from the pin rise to the clock release. These cases tell an off-by-one in the load or terminal test apart from a correct countdown. A second low pulse part way through wake-up separates a restart from a resumed count. A count write during wake-up separates sampling at wake start from live reading. A pin pulse before arming and a disarm during sleep show that the pin only matters while armed and that software always wins. A long random phase drives pin toggles, arm writes and count writes together, and a behavioural model checks every edge, covering overlapping write and pin events.

// File: rtl/dslp_pkg.sv
package dslp_pkg;
  localparam int unsigned DSLP_CNT_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_ASLEEP = 3'd2,
    ST_WAKING = 3'd3,
    ST_DONE   = 3'd4
  } dslp_state_e;
endpackage

// File: rtl/dslp_sync.sv
// Multi-stage level synchroniser; resets to the inactive (high) level.
module dslp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d_async};
  end

  assign q_sync = sh[STAGES-1];
endmodule

// File: rtl/dslp_wake_cnt.sv
// Loadable down-counter timing the oscillator settling window.
module dslp_wake_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/dslp_wake_fsm.sv
// Sleep/wake controller: software writes take priority over pin events.
module dslp_wake_fsm
  import dslp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm_wr,
  input  logic        arm_wdata,
  input  logic        pin_s,
  input  logic        cnt_zero,
  output dslp_state_e st,
  output logic        cnt_load,
  output logic        cnt_dec,
  output logic        gate_en,
  output logic        done_flag,
  output logic        arm_q
);
  dslp_state_e nxt;
  logic        disarm;
  logic        rearm;

  assign disarm = arm_wr && !arm_wdata;
  assign rearm  = arm_wr && arm_wdata && (st == ST_IDLE || st == ST_DONE);

  always_comb begin
    nxt      = st;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (disarm) begin
      nxt = ST_IDLE;
    end else if (rearm) begin
      nxt = ST_ARMED;
    end else begin
      unique case (st)
        ST_ARMED:  if (!pin_s) nxt = ST_ASLEEP;
        ST_ASLEEP: if (pin_s) begin
                     nxt      = ST_WAKING;
                     cnt_load = 1'b1;
                   end
        ST_WAKING: if (!pin_s)       nxt = ST_ASLEEP;
                   else if (cnt_zero) nxt = ST_DONE;
                   else               cnt_dec = 1'b1;
        default:   nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      gate_en   <= 1'b1;
      done_flag <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      st        <= nxt;
      gate_en   <= !(nxt == ST_ASLEEP || nxt == ST_WAKING);
      done_flag <= (nxt == ST_DONE);
      if (arm_wr) arm_q <= arm_wdata;
    end
  end
endmodule

// File: rtl/dslp_wake_seq.sv
module dslp_wake_seq
  import dslp_pkg::*;
#(
  parameter int unsigned CNT_W       = DSLP_CNT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req_n,
  input  logic             arm_wr,
  input  logic             arm_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             arm_q,
  output logic             done_flag,
  output logic [CNT_W-1:0] cnt_q,
  output logic             clk_gate_en
);
  logic             pin_s;
  logic             cnt_zero;
  logic             cnt_load;
  logic             cnt_dec;
  logic [CNT_W-1:0] cfg_cnt;
  dslp_state_e      st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_cnt <= '0;
    else if (cnt_wr) cfg_cnt <= cnt_wdata;
  end
  assign cnt_q = cfg_cnt;

  dslp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(sleep_req_n),
    .q_sync (pin_s)
  );

  dslp_wake_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .load_val(cfg_cnt),
    .dec     (cnt_dec),
    .zero    (cnt_zero)
  );

  dslp_wake_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_wr   (arm_wr),
    .arm_wdata(arm_wdata),
    .pin_s    (pin_s),
    .cnt_zero (cnt_zero),
    .st       (st),
    .cnt_load (cnt_load),
    .cnt_dec  (cnt_dec),
    .gate_en  (clk_gate_en),
    .done_flag(done_flag),
    .arm_q    (arm_q)
  );
endmodule

// File: rtl/dslp_wake_seq_chk.sv
module dslp_wake_seq_chk
  import dslp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        arm_wr,
  input logic        arm_wdata,
  input logic        pin_s,
  input dslp_state_e st,
  input logic        clk_gate_en,
  input logic        done_flag
);
  a_r2_idle_ignores_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !arm_wr) |=> (st == ST_IDLE && clk_gate_en));

  a_r3_low_gates_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED && !pin_s && !arm_wr) |=> (st == ST_ASLEEP && !clk_gate_en));

  a_r5_flag_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $rose(clk_gate_en));

  a_r6_rearm_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && arm_wdata && st == ST_DONE) |=> (!done_flag && st == ST_ARMED));

  a_r7_disarm_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && !arm_wdata) |=> (st == ST_IDLE && clk_gate_en && !done_flag));

  a_r9_relapse_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAKING && !pin_s && !arm_wr) |=> (st == ST_ASLEEP));

  a_r10_gate_off_states: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_gate_en |-> (st == ST_ASLEEP || st == ST_WAKING));
endmodule

bind dslp_wake_seq dslp_wake_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arm_wr     (arm_wr),
  .arm_wdata  (arm_wdata),
  .pin_s      (pin_s),
  .st         (st),
  .clk_gate_en(clk_gate_en),
  .done_flag  (done_flag)
);

// File: tb/dslp_wake_seq_bench.sv
`timescale 1ns/1ps
module dslp_wake_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_req_n = 1'b1;
  logic        arm_wr = 1'b0;
  logic        arm_wdata = 1'b0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        arm_q;
  logic        done_flag;
  logic [15:0] cnt_q;
  logic        clk_gate_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  dslp_wake_seq u_dslp_wake_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req_n(sleep_req_n),
    .arm_wr(arm_wr), .arm_wdata(arm_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .arm_q(arm_q), .done_flag(done_flag), .cnt_q(cnt_q),
    .clk_gate_en(clk_gate_en)
  );

  // Behavioural reference: 0 idle, 1 armed, 2 asleep, 3 waking, 4 done
  int m_st = 0, m_cnt = 0, m_cfg = 0, m_arm = 0;
  int s1 = 1, s2 = 1;

  always @(posedge clk) begin
    int nst;
    int ps;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_cfg = 0; m_arm = 0; s1 = 1; s2 = 1;
    end else begin
      ps  = s2;
      nst = m_st;
      if (arm_wr && !arm_wdata) nst = 0;
      else if (arm_wr && arm_wdata && (m_st == 0 || m_st == 4)) nst = 1;
      else if (m_st == 1) begin
        if (ps == 0) nst = 2;
      end else if (m_st == 2) begin
        if (ps == 1) begin nst = 3; m_cnt = m_cfg; end
      end else if (m_st == 3) begin
        if (ps == 0) nst = 2;
        else if (m_cnt == 0) nst = 4;
        else m_cnt = m_cnt - 1;
      end
      if (cnt_wr) m_cfg = int'(cnt_wdata);
      if (arm_wr) m_arm = int'(arm_wdata);
      s2 = s1;
      s1 = int'(sleep_req_n);
      m_st = nst;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R10", "gate vs model", int'(clk_gate_en), (m_st == 2 || m_st == 3) ? 0 : 1);
      check("R5", "flag vs model", int'(done_flag), (m_st == 4) ? 1 : 0);
      check("R7", "arm readback", int'(arm_q), m_arm);
      check("R8", "count readback", int'(cnt_q), m_cfg);
    end
  end

  task automatic wr_arm(input logic v);
    @(negedge clk); arm_wr = 1'b1; arm_wdata = v;
    @(negedge clk); arm_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive the pin high; return the edges until the clock comes back
  task automatic wake_edges(output int n);
    @(negedge clk); sleep_req_n = 1'b1;
    n = 0;
    while (!clk_gate_en && n < 70000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic sleep_edges(output int n);
    @(negedge clk); sleep_req_n = 1'b0;
    n = 0;
    while (clk_gate_en && n < 20) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n;
    idle(3);
    check("R1", "gate at reset", int'(clk_gate_en), 1);
    check("R1", "flag at reset", int'(done_flag), 0);
    check("R1", "arm at reset", int'(arm_q), 0);
    check("R1", "count at reset", int'(cnt_q), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2: pin low while unarmed
    @(negedge clk); sleep_req_n = 1'b0;
    idle(8);
    check("R2", "gate unarmed", int'(clk_gate_en), 1);
    check("R2", "flag unarmed", int'(done_flag), 0);
    @(negedge clk); sleep_req_n = 1'b1;
    idle(4);

    // R3/R4/R5 count 5
    wr_cnt(16'd5);
    wr_arm(1'b1);
    idle(3);
    sleep_edges(n);
    check("R3", "edges to gate off", n, 3);
    idle(6);
    check("R4", "gated while asleep", int'(clk_gate_en), 0);
    wake_edges(n);
    check("R4", "wake edges N=5", n, 9);
    check("R5", "flag at release", int'(done_flag), 1);

    // R6: rearm from done
    wr_arm(1'b1);
    check("R6", "flag after rearm", int'(done_flag), 0);
    check("R6", "gate after rearm", int'(clk_gate_en), 1);
    sleep_edges(n);
    check("R6", "rearmed sleeps", n, 3);

    // R7: disarm during sleep
    wr_arm(1'b0);
    check("R7", "gate after disarm", int'(clk_gate_en), 1);
    check("R7", "flag after disarm", int'(done_flag), 0);
    idle(4);
    check("R2", "still idle with pin low", int'(clk_gate_en), 1);
    @(negedge clk); sleep_req_n = 1'b1;
    idle(4);

    // R4 count 0
    wr_cnt(16'd0);
    wr_arm(1'b1);
    idle(3);
    sleep_edges(n);
    idle(3);
    wake_edges(n);
    check("R4", "wake edges N=0", n, 4);
    wr_arm(1'b0);
    check("R7", "flag cleared by disarm", int'(done_flag), 0);

    // R9: relapse during waking restarts the count
    wr_cnt(16'd20);
    wr_arm(1'b1);
    idle(3);
    sleep_edges(n);
    idle(3);
    @(negedge clk); sleep_req_n = 1'b1;
    idle(10);
    check("R9", "gated mid-wake", int'(clk_gate_en), 0);
    @(negedge clk); sleep_req_n = 1'b0;
    idle(6);
    check("R9", "back asleep", int'(clk_gate_en), 0);
    wake_edges(n);
    check("R9", "full count after relapse", n, 24);
    wr_arm(1'b0);

    // R8: count write during waking does not disturb countdown
    wr_cnt(16'd10);
    wr_arm(1'b1);
    idle(3);
    sleep_edges(n);
    idle(3);
    @(negedge clk); sleep_req_n = 1'b1;
    idle(4);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 16'd100;
    @(negedge clk); cnt_wr = 1'b0;
    n = 6;
    while (!clk_gate_en && n < 200) begin @(negedge clk); n++; end
    check("R8", "count sampled at wake start", n, 14);
    check("R8", "new count readback", int'(cnt_q), 100);
    wr_arm(1'b0);

    // R8: maximum count
    wr_cnt(16'hFFFF);
    wr_arm(1'b1);
    idle(3);
    sleep_edges(n);
    idle(3);
    wake_edges(n);
    check("R8", "wake edges N=FFFF", n, 65539);
    check("R5", "flag at max release", int'(done_flag), 1);
    wr_arm(1'b0);

    // Random phase, checked each edge by the model (R3, R4, R9, R10)
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      arm_wr = 1'b0; cnt_wr = 1'b0;
      if (($urandom % 12) == 0) sleep_req_n = ~sleep_req_n;
      if (($urandom % 60) == 0) begin arm_wr = 1'b1; arm_wdata = ($urandom % 4) != 0; end
      if (($urandom % 50) == 0) begin cnt_wr = 1'b1; cnt_wdata = 16'($urandom % 16); end
    end
    @(negedge clk); arm_wr = 1'b0; cnt_wr = 1'b0;
    idle(4);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule